// File: doc/BRIEF.md
# Interrupt Cause Register with Grouped Summary Bit

This block collects interrupt causes for a network-controller-style peripheral. Single-cycle hardware event pulses set sticky bits in a 32-bit cause register. A mask register selects which causes may raise the single level interrupt line. Software changes the mask through a set port and a clear port, and it acknowledges causes by writing ones to the cause register.

A group of miscellaneous causes feeds a summary bit. The grouped causes are link status change, receive overrun and four further management-type events. The summary bit can raise the interrupt even when every grouped cause is masked. If software acknowledged only the summary bit, a grouped cause that stayed set would raise the summary bit again and cause an endless interrupt storm. For this reason, a write that acknowledges the summary bit also clears all grouped causes. An optional auto-mask step clears selected mask bits when software acknowledges causes while the interrupt is pending.

Software reaches the block through a simple single-cycle register bus. Writes take effect at the clock edge, and read data is combinational from the current state.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause, mask, auto-mask and control registers all read zero, and `irq_o` is low.
- R2: A one on `hw_evt[b]` sets cause bit b at the next clock edge, and the bit stays set until software clears it. Event bits 24 and 31 have no effect.
- R3: A write to the cause register (address 0) clears each cause bit whose write-data bit is one. Cause bits whose write-data bit is zero keep their value.
- R4: Bit 24 is the summary bit. It becomes one on the clock edge after any of cause bits 2, 6, 9, 16, 17 or 18 is seen set, and it stays one while any of them is set.
- R5: A cause write with data bit 24 set clears the summary bit and cause bits 2, 6, 9, 16, 17 and 18, even when their own data bits are zero. Other cause bits are not affected.
- R6: If a hardware event for a cause bit arrives in the same cycle as a software clear of that bit, the bit stays set.
- R7: `irq_o` is high exactly when the cause register (including the summary bit) ANDed with the mask is nonzero. A masked grouped cause therefore interrupts only through an unmasked bit 24.
- R8: Reads of bit 31 of the cause register return one when any cause is pending. Writes and events never set bit 31.
- R9: A write to address 1 sets the mask bits given by ones in the data. A write to address 2 clears them. A read of address 1 or address 2 returns the mask.
- R10: A cause write in a cycle where an interrupt is pending and control bit 0 is one also clears the mask bits selected by the auto-mask register (address 3).
- R11: The auto-mask register (address 3) and the control register (address 4) read back what was written. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt | input | 32 | Hardware cause pulses, one per cause bit |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench recreates the interrupt storm. It masks receive overrun, unmasks only the summary bit, then acknowledges the summary bit. If the design cleared only bit 24, bit 24 would come back on the next edge and `irq_o` would fire again. The bench also checks the one-cycle lag of the summary bit behind a grouped cause, a clear in the same cycle as an event (a design where the clear won would lose that event), and auto-masking, which must use the pending state from before the write. Random traffic is compared against a cycle model, which catches read-port or mask-port mix-ups and a bit 31 that software could write.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam int A_CAUSE = 0;
  localparam int A_MSET  = 1;
  localparam int A_MCLR  = 2;
  localparam int A_AMASK = 3;
  localparam int A_XCTRL = 4;

  // next stored causes after an optional one-to-clear write
  function automatic word_t w1c_next(word_t old, word_t wd, logic wr,
                                     word_t grp, int unsigned sbit);
    word_t r;
    r = old;
    if (wr) begin
      r = old & ~wd;
      if (wd[sbit]) r = r & ~grp;
    end
    return r;
  endfunction

  function automatic logic any_pending(word_t vis, word_t msk);
    return |(vis & msk);
  endfunction

  function automatic word_t mask_next(word_t m, word_t wd, logic wr_set,
                                      logic wr_clr, logic do_am, word_t am);
    word_t r;
    r = m;
    if (do_am)  r = r & ~am;
    if (wr_set) r = r | wd;
    if (wr_clr) r = r & ~wd;
    return r;
  endfunction
endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec #(
  parameter int ADDR_W = 3
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_cause,
  output logic              wr_mset,
  output logic              wr_mclr,
  output logic              wr_amask,
  output logic              wr_xctrl
);
  import irq_cause_pkg::*;
  always_comb begin
    wr_cause = we && (addr == ADDR_W'(A_CAUSE));
    wr_mset  = we && (addr == ADDR_W'(A_MSET));
    wr_mclr  = we && (addr == ADDR_W'(A_MCLR));
    wr_amask = we && (addr == ADDR_W'(A_AMASK));
    wr_xctrl = we && (addr == ADDR_W'(A_XCTRL));
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned               SUM_BIT  = 24,
  parameter int unsigned               FLAG_BIT = 31,
  parameter irq_cause_pkg::word_t      GROUP    = 32'h0007_0244
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  irq_cause_pkg::word_t evt,
  input  logic                 wr_cause,
  input  irq_cause_pkg::word_t wdata,
  output irq_cause_pkg::word_t cause_vis
);
  import irq_cause_pkg::*;

  localparam word_t SPECIAL = (word_t'(1) << SUM_BIT) | (word_t'(1) << FLAG_BIT);
  localparam word_t STORE   = ~SPECIAL;

  word_t cause_q, cause_d;
  logic  summ_q, summ_d;
  logic  summ_clr;   // named event: software acknowledged the summary bit
  logic  grp_any;    // named event: a grouped cause is held

  always_comb begin
    summ_clr = wr_cause && wdata[SUM_BIT];
    grp_any  = |(cause_q & GROUP);
    cause_d  = (w1c_next(cause_q, wdata, wr_cause, GROUP, SUM_BIT) | evt) & STORE;
    summ_d   = summ_clr ? 1'b0 : grp_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      summ_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      summ_q  <= summ_d;
    end
  end

  always_comb begin
    cause_vis = cause_q;
    cause_vis[SUM_BIT] = summ_q;
  end

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & STORE)) |=> ((cause_q & $past(evt & STORE)) == $past(evt & STORE))); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> ((cause_q & $past(wdata & ~evt & STORE)) == '0)); // R3
  AST_GROUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && wdata[SUM_BIT]) |=> (((cause_q & GROUP & ~$past(evt)) == '0) && !summ_q)); // R5
  AST_SUMM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(cause_q & GROUP)) && !(wr_cause && wdata[SUM_BIT])) |=> summ_q); // R4
  AST_FLAG_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_q[FLAG_BIT]); // R8
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned AM_EN_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cause,
  input  logic                 wr_mset,
  input  logic                 wr_mclr,
  input  logic                 wr_amask,
  input  logic                 wr_xctrl,
  input  irq_cause_pkg::word_t wdata,
  input  logic                 pend_any,
  output irq_cause_pkg::word_t mask_q,
  output irq_cause_pkg::word_t amask_q,
  output irq_cause_pkg::word_t xctrl_q
);
  import irq_cause_pkg::*;

  logic do_am;   // named event: auto-mask fires on this write

  always_comb do_am = wr_cause && pend_any && xctrl_q[AM_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      amask_q <= '0;
      xctrl_q <= '0;
    end else begin
      mask_q <= mask_next(mask_q, wdata, wr_mset, wr_mclr, do_am, amask_q);
      if (wr_amask) amask_q <= wdata;
      if (wr_xctrl) xctrl_q <= wdata;
    end
  end

  AST_AUTOMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && pend_any && xctrl_q[AM_EN_BIT]) |=> ((mask_q & $past(amask_q)) == '0)); // R10
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(wdata)) == $past(wdata))); // R9
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & $past(wdata)) == '0)); // R9
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int unsigned          ADDR_W    = 3,
  parameter int unsigned          SUM_BIT   = 24,
  parameter int unsigned          FLAG_BIT  = 31,
  parameter int unsigned          AM_EN_BIT = 0,
  parameter irq_cause_pkg::word_t GROUP     = 32'h0007_0244
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       hw_evt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  import irq_cause_pkg::*;

  logic  wr_cause, wr_mset, wr_mclr, wr_amask, wr_xctrl;
  word_t cause_vis, mask_q, amask_q, xctrl_q;
  logic  pend_any;

  irq_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .we(bus_we), .addr(bus_addr), .wr_cause(wr_cause), .wr_mset(wr_mset),
    .wr_mclr(wr_mclr), .wr_amask(wr_amask), .wr_xctrl(wr_xctrl)
  );

  irq_cause_reg #(.SUM_BIT(SUM_BIT), .FLAG_BIT(FLAG_BIT), .GROUP(GROUP)) u_cause (
    .clk(clk), .rst_n(rst_n), .evt(hw_evt), .wr_cause(wr_cause),
    .wdata(bus_wdata), .cause_vis(cause_vis)
  );

  irq_mask_reg #(.AM_EN_BIT(AM_EN_BIT)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_cause(wr_cause), .wr_mset(wr_mset),
    .wr_mclr(wr_mclr), .wr_amask(wr_amask), .wr_xctrl(wr_xctrl),
    .wdata(bus_wdata), .pend_any(pend_any), .mask_q(mask_q),
    .amask_q(amask_q), .xctrl_q(xctrl_q)
  );

  always_comb begin
    pend_any = any_pending(cause_vis, mask_q);
    irq_o    = pend_any;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CAUSE): begin
        bus_rdata = cause_vis;
        bus_rdata[FLAG_BIT] = pend_any;
      end
      ADDR_W'(A_MSET), ADDR_W'(A_MCLR): bus_rdata = mask_q;
      ADDR_W'(A_AMASK): bus_rdata = amask_q;
      ADDR_W'(A_XCTRL): bus_rdata = xctrl_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|mask_q)); // R7
  AST_IRQ_LOW_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_vis == '0) |-> !irq_o); // R7
endmodule

// File: tb/tb_irq_cause_unit.sv
module tb_irq_cause_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_evt = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #5 clk = ~clk;

  irq_cause_unit dut (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [31:0] GRP   = 32'h0007_0244;
  localparam logic [31:0] KEEP  = ~(32'h8100_0000);

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  // bench model state
  logic [31:0] m_cause = '0;   // stored causes, bits 24 and 31 always zero
  logic        m_summ = 1'b0;
  logic [31:0] m_mask = '0, m_am = '0, m_xc = '0;

  function automatic logic [31:0] vis_of(logic [31:0] c, logic s);
    logic [31:0] v;
    v = c;
    v[24] = s;
    return v;
  endfunction

  function automatic logic pend_of(logic [31:0] c, logic s, logic [31:0] m);
    return (vis_of(c, s) & m) != 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_we = 1'b0;
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // compare the cause, mask and interrupt line with the model
  task automatic compare_all();
    logic [31:0] d, e;
    logic p;
    p = pend_of(m_cause, m_summ, m_mask);
    e = vis_of(m_cause, m_summ);
    e[31] = p;
    rd(3'd0, d); check("R3 cause readback", d, e);
    rd(3'd1, d); check("R9 mask readback", d, m_mask);
    check("R7 irq level", {31'd0, irq_o}, {31'd0, p});
  endtask

  // one cycle of stimulus; the model moves at the edge, then compare
  task automatic step(logic [31:0] evt, logic we, logic [2:0] a, logic [31:0] wd);
    logic p, wc, s_n;
    logic [31:0] c_n;
    hw_evt = evt; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    p  = pend_of(m_cause, m_summ, m_mask);
    wc = we && (a == 3'd0);
    c_n = m_cause;
    if (wc) begin
      c_n = c_n & ~wd;
      if (wd[24]) c_n = c_n & ~GRP;
    end
    c_n = (c_n | evt) & KEEP;
    s_n = (wc && wd[24]) ? 1'b0 : ((m_cause & GRP) != 0);
    if (wc && p && m_xc[0]) m_mask = m_mask & ~m_am;
    if (we && a == 3'd1) m_mask = m_mask | wd;
    if (we && a == 3'd2) m_mask = m_mask & ~wd;
    if (we && a == 3'd3) m_am = wd;
    if (we && a == 3'd4) m_xc = wd;
    m_cause = c_n;
    m_summ  = s_n;
    @(negedge clk);
    hw_evt = '0; bus_we = 1'b0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    rd(3'd0, d); check("R1 cause after reset", d, 32'h0);
    rd(3'd1, d); check("R1 mask after reset", d, 32'h0);
    rd(3'd3, d); check("R1 automask after reset", d, 32'h0);
    rd(3'd4, d); check("R1 control after reset", d, 32'h0);
    check("R1 irq after reset", {31'd0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: event sets sticky bit; R8: events on 24/31 ignored
    step(32'h0000_0001, 1'b0, 3'd0, 32'h0);
    step(32'h0, 1'b0, 3'd0, 32'h0);
    rd(3'd0, d); check("R2 sticky cause bit0", d, 32'h0000_0001);
    step(32'h8100_0000, 1'b0, 3'd0, 32'h0);
    rd(3'd0, d); check("R8 events on bits 24/31 ignored", d, 32'h0000_0001);

    // R4: summary lags a grouped cause by one edge
    step(32'h0000_0200, 1'b0, 3'd0, 32'h0);
    rd(3'd0, d); check("R4 summary not yet set", d, 32'h0000_0201);
    step(32'h0, 1'b0, 3'd0, 32'h0);
    rd(3'd0, d); check("R4 summary set next edge", d, 32'h0100_0201);

    // R3: clear bit0 only, zero bits untouched
    step(32'h0, 1'b1, 3'd0, 32'h0000_0001);
    rd(3'd0, d); check("R3 clear only written bit", d, 32'h0100_0200);

    // R5: storm scenario - overrun masked, only summary unmasked
    step(32'h0, 1'b1, 3'd1, 32'h0100_0000);
    step(32'h0000_0040, 1'b0, 3'd0, 32'h0);
    step(32'h0000_0010, 1'b0, 3'd0, 32'h0);
    check("R7 masked overrun interrupts via summary", {31'd0, irq_o}, 32'h1);
    step(32'h0, 1'b1, 3'd0, 32'h0100_0000);
    rd(3'd0, d); check("R5 summary ack clears group only", d, 32'h0000_0010);
    step(32'h0, 1'b0, 3'd0, 32'h0);
    step(32'h0, 1'b0, 3'd0, 32'h0);
    check("R5 no storm after ack", {31'd0, irq_o}, 32'h0);
    rd(3'd0, d); check("R5 summary stays low", d, 32'h0000_0010);

    // R6: event in same cycle as clear wins
    step(32'h0000_0010, 1'b1, 3'd0, 32'h0000_0010);
    rd(3'd0, d); check("R6 event beats clear", d, 32'h0000_0010);
    step(32'h0, 1'b1, 3'd0, 32'h0000_0010);

    // R8: bit 31 not writable through mask path either; write to cause bit 31 no effect
    step(32'h0, 1'b1, 3'd0, 32'h8000_0000);
    rd(3'd0, d); check("R8 flag not writable", d, 32'h0);

    // R9: clear port
    step(32'h0, 1'b1, 3'd1, 32'h0000_00F0);
    step(32'h0, 1'b1, 3'd2, 32'h0100_0030);
    rd(3'd2, d); check("R9 mask via clear port", d, 32'h0000_00C0);

    // R10: auto-mask
    step(32'h0, 1'b1, 3'd3, 32'h0000_0040);
    step(32'h0, 1'b1, 3'd4, 32'h0000_0001);
    step(32'h0000_0040, 1'b0, 3'd0, 32'h0);
    step(32'h0, 1'b1, 3'd0, 32'h0000_0001);
    rd(3'd1, d); check("R10 auto-mask cleared selected bits", d, 32'h0000_0080);
    step(32'h0, 1'b1, 3'd0, 32'h0100_0040);

    // R11: readback and unused addresses
    rd(3'd3, d); check("R11 automask readback", d, 32'h0000_0040);
    rd(3'd4, d); check("R11 control readback", d, 32'h0000_0001);
    rd(3'd5, d); check("R11 unused address reads zero", d, 32'h0);
    rd(3'd7, d); check("R11 unused address 7 reads zero", d, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ev, wd;
      logic we;
      logic [2:0] a;
      ev = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
      we = ($urandom % 3 == 0);
      a  = 3'($urandom % 6);
      wd = ($urandom % 2 == 0) ? ($urandom & $urandom) : (32'h1 << ($urandom % 32));
      step(ev, we, a, wd);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule